// File: doc/BRIEF.md
# Adaptive Subsampled Block Matcher

This block finds the motion vector of one 16x16 current macroblock. It runs an exhaustive block-matching search over a rectangular window of a reference picture. It does not compare all 256 pixels for each candidate. While the block is being loaded, it picks 32 pixel positions out of it, one per run of eight consecutive raster pixels. The pick follows the block's own values: alternate runs keep their largest and their smallest pixel. Each candidate's distortion is then summed over those 32 positions only, so each candidate costs one eighth of the arithmetic of a dense comparison.

To use it, stream the block in raster order on the load port. Then pulse `start` with a window centre, given relative to the block's top-left corner. The block then reads the reference picture through a read port with a one-cycle latency, fetching one pixel per cycle. When the scan completes it pulses `done` and presents the winning displacement and its distortion. Picture storage and rate control sit outside.

Top module: `mbm_matcher`

## Requirements
- R1: While idle, each cycle with `cur_valid` high stores `cur_pix` as the next raster pixel of the block (index 0 first, index = row*16 + column). A block counts as present once 256 pixels have been taken. A `start` before the first complete block is ignored: no read is issued and no `done` follows.
- R2: Pixels are grouped as indices 8g to 8g+7 for g = 0..31. An even-numbered group keeps the position of its largest value and an odd-numbered group the position of its smallest. On equal values the lowest index in the group is kept.
- R3: The distortion of a candidate is the sum, over the 32 kept positions, of the absolute difference between the stored block value and the reference pixel at that position shifted by the candidate displacement. It never exceeds 32*255.
- R4: Candidate displacements cover every horizontal offset from -RNG_H to +RNG_H and every vertical offset from -RNG_V to +RNG_V around the centre latched at the accepted `start` (defaults 32 and 16). Each candidate takes exactly 32 reads, so a search issues (2*RNG_H+1)*(2*RNG_V+1)*32 reads.
- R5: Candidates are visited with the vertical offset as the outer loop and the horizontal offset as the inner loop, both ascending. A candidate replaces the current best only if its distortion is strictly smaller, so on equal distortion the earliest candidate is kept.
- R6: While `ref_rd` is high, `ref_x`/`ref_y` give a signed reference coordinate relative to the block's top-left corner: centre + displacement + (column, row) of the kept position. The pixel is expected on `ref_pix` in the following cycle. Every read falls within the window extended by the block size.
- R7: `done` is high for exactly one cycle. In that cycle `mv_x`/`mv_y` hold centre + winning displacement and `mv_sad` holds its distortion. These outputs keep their values until the next `done`.
- R8: `busy` rises in the cycle after an accepted `start` and is low again in the `done` cycle. While `busy` is high, `start` and `cur_valid` are ignored: the running search and the stored block are not changed.
- R9: After reset `busy`, `done` and `ref_rd` are low and `mv_x`, `mv_y`, `mv_sad` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cur_valid | input | 1 | Current-block pixel strobe |
| cur_pix | input | PIX_W | Current-block pixel, raster order |
| start | input | 1 | Begin a search |
| ctr_x | input | CRD_W | Signed horizontal window centre |
| ctr_y | input | CRD_W | Signed vertical window centre |
| ref_rd | output | 1 | Reference read request |
| ref_x | output | CRD_W | Signed reference column |
| ref_y | output | CRD_W | Signed reference row |
| ref_pix | input | PIX_W | Reference pixel, one cycle after the request |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| mv_x | output | CRD_W | Signed horizontal motion vector |
| mv_y | output | CRD_W | Signed vertical motion vector |
| mv_sad | output | SAD_W | Distortion of the winning candidate |

## Verification
Two things can land in the same cycle: the strict-improvement comparison of the very last candidate and the end-of-scan completion. The result must then come from that last candidate and not from the best held before it. The bench provokes this by planting an exact copy of the block at the bottom-right displacement of the window. The search must then report that corner with zero distortion. Flat-valued blocks and references set up ties both in the pixel selection and in the candidate comparison. A bench model built from the requirements predicts the exact vector and distortion.

// File: rtl/mbm_pkg.sv
package mbm_pkg;
    typedef enum logic {
        SCAN_IDLE = 1'b0,
        SCAN_RUN  = 1'b1
    } scan_st_e;
endpackage

// File: rtl/mbm_pick.sv
// Chooses one position per group of GRP raster pixels while the block streams in.
module mbm_pick #(
    parameter int PIX_W = 8,
    parameter int GRP   = 8,
    parameter int NGRP  = 32,
    parameter int IDX_W = 8
)(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load_en,
    input  logic [PIX_W-1:0]              pix,
    output logic [NGRP-1:0][IDX_W-1:0]    sel_off,
    output logic [NGRP-1:0][PIX_W-1:0]    sel_val,
    output logic                          full
);
    localparam int GI_W = $clog2(GRP);
    localparam int GN_W = IDX_W - GI_W;

    typedef struct packed {
        logic [IDX_W-1:0]               idx;
        logic [PIX_W-1:0]               ext_val;
        logic [IDX_W-1:0]               ext_pos;
        logic [NGRP-1:0][IDX_W-1:0]     offs;
        logic [NGRP-1:0][PIX_W-1:0]     vals;
        logic                           full;
    } pick_t;

    pick_t s_d, s_q;

    logic [GN_W-1:0]  grp;
    logic             grp_first;
    logic             grp_last;
    logic             keep_max;
    logic             better;
    logic             take;
    logic [PIX_W-1:0] new_val;
    logic [IDX_W-1:0] new_pos;

    always_comb begin
        grp       = s_q.idx[IDX_W-1:GI_W];
        grp_first = (s_q.idx[GI_W-1:0] == '0);
        grp_last  = (s_q.idx[GI_W-1:0] == GI_W'(GRP - 1));
        keep_max  = ~grp[0];
        // strict compares keep the earliest index on equal values
        better    = keep_max ? (pix > s_q.ext_val) : (pix < s_q.ext_val);
        take      = grp_first | better;
        new_val   = take ? pix : s_q.ext_val;
        new_pos   = take ? s_q.idx : s_q.ext_pos;

        s_d = s_q;
        if (load_en) begin
            s_d.idx     = s_q.idx + 1'b1;
            s_d.ext_val = new_val;
            s_d.ext_pos = new_pos;
            if (grp_last) begin
                s_d.offs[grp] = new_pos;
                s_d.vals[grp] = new_val;
            end
            if (s_q.idx == '1) begin
                s_d.full = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sel_off = s_q.offs;
    assign sel_val = s_q.vals;
    assign full    = s_q.full;
endmodule

// File: rtl/mbm_scan.sv
// Walks every candidate displacement and issues one reference read per cycle.
module mbm_scan
    import mbm_pkg::*;
#(
    parameter int NGRP  = 32,
    parameter int K_W   = 5,
    parameter int IDX_W = 8,
    parameter int BLK   = 16,
    parameter int RNG_H = 32,
    parameter int RNG_V = 16,
    parameter int CRD_W = 12
)(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          go,
    input  logic signed [CRD_W-1:0]       ctr_x,
    input  logic signed [CRD_W-1:0]       ctr_y,
    input  logic [NGRP-1:0][IDX_W-1:0]    sel_off,
    output logic                          active,
    output logic [K_W-1:0]                iss_k,
    output logic                          iss_clast,
    output logic                          iss_final,
    output logic signed [CRD_W-1:0]       iss_mvx,
    output logic signed [CRD_W-1:0]       iss_mvy,
    output logic signed [CRD_W-1:0]       rx,
    output logic signed [CRD_W-1:0]       ry
);
    localparam int CB = $clog2(BLK);
    localparam logic signed [CRD_W-1:0] DX_HI = CRD_W'(RNG_H);
    localparam logic signed [CRD_W-1:0] DX_LO = -DX_HI;
    localparam logic signed [CRD_W-1:0] DY_HI = CRD_W'(RNG_V);
    localparam logic signed [CRD_W-1:0] DY_LO = -DY_HI;
    localparam logic signed [CRD_W-1:0] ONE   = CRD_W'(1);

    typedef struct packed {
        scan_st_e                 st;
        logic [K_W-1:0]           k;
        logic signed [CRD_W-1:0]  dx;
        logic signed [CRD_W-1:0]  dy;
        logic signed [CRD_W-1:0]  cx;
        logic signed [CRD_W-1:0]  cy;
    } scan_t;

    scan_t s_d, s_q;

    logic             last_k;
    logic             dx_end;
    logic             dy_end;
    logic [IDX_W-1:0] off;
    logic [CB-1:0]    col;
    logic [IDX_W-CB-1:0] row;

    always_comb begin
        last_k = (s_q.k == K_W'(NGRP - 1));
        dx_end = (s_q.dx == DX_HI);
        dy_end = (s_q.dy == DY_HI);
        off    = sel_off[s_q.k];
        col    = off[CB-1:0];
        row    = off[IDX_W-1:CB];

        iss_mvx   = s_q.cx + s_q.dx;
        iss_mvy   = s_q.cy + s_q.dy;
        rx        = iss_mvx + $signed({{(CRD_W-CB){1'b0}}, col});
        ry        = iss_mvy + $signed({{(CRD_W-IDX_W+CB){1'b0}}, row});
        active    = (s_q.st == SCAN_RUN);
        iss_k     = s_q.k;
        iss_clast = last_k;
        iss_final = active & last_k & dx_end & dy_end;

        s_d = s_q;
        if (s_q.st == SCAN_IDLE) begin
            if (go) begin
                s_d.st = SCAN_RUN;
                s_d.k  = '0;
                s_d.dx = DX_LO;
                s_d.dy = DY_LO;
                s_d.cx = ctr_x;
                s_d.cy = ctr_y;
            end
        end else begin
            s_d.k = s_q.k + 1'b1;
            if (last_k) begin
                s_d.k = '0;
                if (dx_end) begin
                    s_d.dx = DX_LO;
                    if (dy_end) begin
                        s_d.st = SCAN_IDLE;
                    end else begin
                        s_d.dy = s_q.dy + ONE;
                    end
                end else begin
                    s_d.dx = s_q.dx + ONE;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/mbm_sad.sv
// Aligns returning reference data, sums distortion, keeps the best candidate.
module mbm_sad #(
    parameter int PIX_W = 8,
    parameter int SAD_W = 13,
    parameter int CRD_W = 12
)(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    go,
    input  logic                    iss_rd,
    input  logic                    iss_clast,
    input  logic                    iss_final,
    input  logic signed [CRD_W-1:0] iss_mvx,
    input  logic signed [CRD_W-1:0] iss_mvy,
    input  logic [PIX_W-1:0]        iss_cval,
    input  logic [PIX_W-1:0]        ref_pix,
    output logic                    pend,
    output logic                    done,
    output logic signed [CRD_W-1:0] mv_x,
    output logic signed [CRD_W-1:0] mv_y,
    output logic [SAD_W-1:0]        mv_sad
);
    typedef struct packed {
        logic                    p_vld;
        logic                    p_clast;
        logic                    p_final;
        logic signed [CRD_W-1:0] p_mvx;
        logic signed [CRD_W-1:0] p_mvy;
        logic [PIX_W-1:0]        p_cval;
        logic [SAD_W-1:0]        acc;
        logic [SAD_W-1:0]        b_sad;
        logic signed [CRD_W-1:0] b_x;
        logic signed [CRD_W-1:0] b_y;
        logic                    done;
        logic signed [CRD_W-1:0] o_x;
        logic signed [CRD_W-1:0] o_y;
        logic [SAD_W-1:0]        o_sad;
    } sad_t;

    sad_t s_d, s_q;

    logic [PIX_W-1:0]        diff;
    logic [SAD_W-1:0]        tot;
    logic                    win;
    logic [SAD_W-1:0]        nb_sad;
    logic signed [CRD_W-1:0] nb_x;
    logic signed [CRD_W-1:0] nb_y;

    always_comb begin
        diff   = (ref_pix >= s_q.p_cval) ? (ref_pix - s_q.p_cval) : (s_q.p_cval - ref_pix);
        tot    = s_q.acc + SAD_W'(diff);
        win    = (tot < s_q.b_sad);
        nb_sad = win ? tot : s_q.b_sad;
        nb_x   = win ? s_q.p_mvx : s_q.b_x;
        nb_y   = win ? s_q.p_mvy : s_q.b_y;

        s_d         = s_q;
        s_d.p_vld   = iss_rd;
        s_d.p_clast = iss_clast;
        s_d.p_final = iss_final;
        s_d.p_mvx   = iss_mvx;
        s_d.p_mvy   = iss_mvy;
        s_d.p_cval  = iss_cval;
        s_d.done    = 1'b0;

        if (go) begin
            s_d.acc   = '0;
            s_d.b_sad = '1;
        end

        if (s_q.p_vld) begin
            if (s_q.p_clast) begin
                s_d.acc   = '0;
                s_d.b_sad = nb_sad;
                s_d.b_x   = nb_x;
                s_d.b_y   = nb_y;
                if (s_q.p_final) begin
                    s_d.done  = 1'b1;
                    s_d.o_sad = nb_sad;
                    s_d.o_x   = nb_x;
                    s_d.o_y   = nb_y;
                end
            end else begin
                s_d.acc = tot;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pend   = s_q.p_vld;
    assign done   = s_q.done;
    assign mv_x   = s_q.o_x;
    assign mv_y   = s_q.o_y;
    assign mv_sad = s_q.o_sad;
endmodule

// File: rtl/mbm_matcher.sv
module mbm_matcher #(
    parameter int PIX_W = 8,
    parameter int BLK   = 16,
    parameter int GRP   = 8,
    parameter int RNG_H = 32,
    parameter int RNG_V = 16,
    parameter int CRD_W = 12,
    parameter int SAD_W = 13
)(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cur_valid,
    input  logic [PIX_W-1:0]        cur_pix,
    input  logic                    start,
    input  logic signed [CRD_W-1:0] ctr_x,
    input  logic signed [CRD_W-1:0] ctr_y,
    output logic                    ref_rd,
    output logic signed [CRD_W-1:0] ref_x,
    output logic signed [CRD_W-1:0] ref_y,
    input  logic [PIX_W-1:0]        ref_pix,
    output logic                    busy,
    output logic                    done,
    output logic signed [CRD_W-1:0] mv_x,
    output logic signed [CRD_W-1:0] mv_y,
    output logic [SAD_W-1:0]        mv_sad
);
    localparam int NPIX  = BLK * BLK;
    localparam int NGRP  = NPIX / GRP;
    localparam int IDX_W = $clog2(NPIX);
    localparam int K_W   = $clog2(NGRP);

    logic [NGRP-1:0][IDX_W-1:0] sel_off;
    logic [NGRP-1:0][PIX_W-1:0] sel_val;
    logic                       blk_full;
    logic                       scan_act;
    logic                       pend;
    logic                       go;
    logic                       load_en;
    logic [K_W-1:0]             iss_k;
    logic                       iss_clast;
    logic                       iss_final;
    logic signed [CRD_W-1:0]    iss_mvx;
    logic signed [CRD_W-1:0]    iss_mvy;

    assign busy    = scan_act | pend;
    assign go      = start & ~busy & blk_full;
    assign load_en = cur_valid & ~busy;
    assign ref_rd  = scan_act;

    mbm_pick #(
        .PIX_W (PIX_W),
        .GRP   (GRP),
        .NGRP  (NGRP),
        .IDX_W (IDX_W)
    ) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .pix     (cur_pix),
        .sel_off (sel_off),
        .sel_val (sel_val),
        .full    (blk_full)
    );

    mbm_scan #(
        .NGRP  (NGRP),
        .K_W   (K_W),
        .IDX_W (IDX_W),
        .BLK   (BLK),
        .RNG_H (RNG_H),
        .RNG_V (RNG_V),
        .CRD_W (CRD_W)
    ) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .ctr_x     (ctr_x),
        .ctr_y     (ctr_y),
        .sel_off   (sel_off),
        .active    (scan_act),
        .iss_k     (iss_k),
        .iss_clast (iss_clast),
        .iss_final (iss_final),
        .iss_mvx   (iss_mvx),
        .iss_mvy   (iss_mvy),
        .rx        (ref_x),
        .ry        (ref_y)
    );

    mbm_sad #(
        .PIX_W (PIX_W),
        .SAD_W (SAD_W),
        .CRD_W (CRD_W)
    ) u_sad (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .iss_rd    (scan_act),
        .iss_clast (iss_clast),
        .iss_final (iss_final),
        .iss_mvx   (iss_mvx),
        .iss_mvy   (iss_mvy),
        .iss_cval  (sel_val[iss_k]),
        .ref_pix   (ref_pix),
        .pend      (pend),
        .done      (done),
        .mv_x      (mv_x),
        .mv_y      (mv_y),
        .mv_sad    (mv_sad)
    );
endmodule

// File: rtl/mbm_matcher_chk.sv
module mbm_matcher_chk #(
    parameter int PIX_W = 8,
    parameter int NGRP  = 32,
    parameter int RNG_H = 32,
    parameter int RNG_V = 16,
    parameter int CRD_W = 12,
    parameter int SAD_W = 13
)(
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic                    busy,
    input logic                    ref_rd,
    input logic                    done,
    input logic signed [CRD_W-1:0] ctr_x,
    input logic signed [CRD_W-1:0] ctr_y,
    input logic signed [CRD_W-1:0] mv_x,
    input logic signed [CRD_W-1:0] mv_y,
    input logic [SAD_W-1:0]        mv_sad
);
    localparam int NREAD   = (2 * RNG_H + 1) * (2 * RNG_V + 1) * NGRP;
    localparam int SAD_MAX = NGRP * ((1 << PIX_W) - 1);
    localparam logic signed [CRD_W-1:0] RH = CRD_W'(RNG_H);
    localparam logic signed [CRD_W-1:0] RV = CRD_W'(RNG_V);

    logic [31:0]             rd_cnt;
    logic signed [CRD_W-1:0] lat_x;
    logic signed [CRD_W-1:0] lat_y;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_cnt <= '0;
            lat_x  <= '0;
            lat_y  <= '0;
        end else begin
            if (done) begin
                rd_cnt <= '0;
            end else if (ref_rd) begin
                rd_cnt <= rd_cnt + 32'd1;
            end
            if (start && !busy) begin
                lat_x <= ctr_x;
                lat_y <= ctr_y;
            end
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                     // R7
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(mv_x) && $stable(mv_y) && $stable(mv_sad)));      // R7
    AST_RD_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ref_rd |-> busy);                                                    // R8
    AST_READS_EXHAUSTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rd_cnt == 32'(NREAD)));                                    // R4
    AST_SAD_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mv_sad <= SAD_W'(SAD_MAX)));                               // R3
    AST_VEC_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((mv_x >= lat_x - RH) && (mv_x <= lat_x + RH) &&
                  (mv_y >= lat_y - RV) && (mv_y <= lat_y + RV)));            // R4
endmodule

bind mbm_matcher mbm_matcher_chk #(
    .PIX_W (PIX_W),
    .NGRP  (NGRP),
    .RNG_H (RNG_H),
    .RNG_V (RNG_V),
    .CRD_W (CRD_W),
    .SAD_W (SAD_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .ref_rd (ref_rd),
    .done   (done),
    .ctr_x  (ctr_x),
    .ctr_y  (ctr_y),
    .mv_x   (mv_x),
    .mv_y   (mv_y),
    .mv_sad (mv_sad)
);

// File: tb/tb_mbm_matcher.sv
module tb_mbm_matcher;
    localparam int PIX_W = 8;
    localparam int BLK   = 16;
    localparam int GRP   = 8;
    localparam int RNG_H = 3;
    localparam int RNG_V = 2;
    localparam int CRD_W = 10;
    localparam int SAD_W = 13;
    localparam int NPIX  = BLK * BLK;
    localparam int NGRP  = NPIX / GRP;
    localparam int NREAD = (2 * RNG_H + 1) * (2 * RNG_V + 1) * NGRP;

    typedef struct packed {
        int cseed;
        int rseed;
        int cx;
        int cy;
        int px;
        int py;
        int plant;
    } vec_t;

    // seed -1 means a flat value of 100
    localparam vec_t VECS [6] = '{
        '{1,  7,  0,  0,  1, -1, 1},
        '{2,  9,  5, -3, -3, -2, 1},
        '{3, 11, -4,  6,  3,  2, 1},
        '{-1, 5,  2,  2,  0,  0, 0},
        '{-1, -1, 1, -1,  0,  0, 0},
        '{4, 13,  0,  0,  0,  0, 0}
    };

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    cur_valid = 1'b0;
    logic [PIX_W-1:0]        cur_pix = '0;
    logic                    start = 1'b0;
    logic signed [CRD_W-1:0] ctr_x = '0;
    logic signed [CRD_W-1:0] ctr_y = '0;
    logic                    ref_rd;
    logic signed [CRD_W-1:0] ref_x;
    logic signed [CRD_W-1:0] ref_y;
    logic [PIX_W-1:0]        ref_pix = '0;
    logic                    busy;
    logic                    done;
    logic signed [CRD_W-1:0] mv_x;
    logic signed [CRD_W-1:0] mv_y;
    logic [SAD_W-1:0]        mv_sad;

    always #10 clk = ~clk;

    mbm_matcher #(
        .PIX_W (PIX_W), .BLK (BLK), .GRP (GRP), .RNG_H (RNG_H),
        .RNG_V (RNG_V), .CRD_W (CRD_W), .SAD_W (SAD_W)
    ) dut (
        .clk (clk), .rst_n (rst_n), .cur_valid (cur_valid), .cur_pix (cur_pix),
        .start (start), .ctr_x (ctr_x), .ctr_y (ctr_y), .ref_rd (ref_rd),
        .ref_x (ref_x), .ref_y (ref_y), .ref_pix (ref_pix), .busy (busy),
        .done (done), .mv_x (mv_x), .mv_y (mv_y), .mv_sad (mv_sad)
    );

    int  n_chk = 0;
    int  n_err = 0;
    bit  finished = 0;
    int  cur [NPIX];
    int  cx = 0, cy = 0, px = 0, py = 0, plant = 0, rseed = 0;
    int  rd_cnt = 0, win_bad = 0;
    int  exp_x, exp_y, exp_sad;

    function automatic int hsh(int a, int b, int c);
        return ((a * 73 + b * 151 + c * 29 + a * b * 7 + b * c * 3) ^ (a * c * 11 + (a >> 2) * b)) & 255;
    endfunction

    function automatic int pix_at(int x, int y);
        int ox, oy;
        ox = x - (cx + px);
        oy = y - (cy + py);
        if (plant != 0 && ox >= 0 && ox < BLK && oy >= 0 && oy < BLK) return cur[oy * BLK + ox];
        if (rseed < 0) return 100;
        return hsh(x + 64, y + 64, rseed);
    endfunction

    // reference memory, one-cycle read latency
    always @(posedge clk) begin
        if (ref_rd) ref_pix <= 8'(pix_at(int'(ref_x), int'(ref_y)));
    end

    always @(negedge clk) begin
        if (ref_rd) begin
            rd_cnt++;
            if (int'(ref_x) < cx - RNG_H || int'(ref_x) > cx + RNG_H + BLK - 1 ||
                int'(ref_y) < cy - RNG_V || int'(ref_y) > cy + RNG_V + BLK - 1) win_bad++;
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic load_block(input int seed);
        for (int i = 0; i < NPIX; i++) begin
            cur[i] = (seed < 0) ? 100 : hsh(i, i >> 4, seed);
            cur_valid = 1'b1;
            cur_pix = 8'(cur[i]);
            @(negedge clk);
        end
        cur_valid = 1'b0;
    endtask

    // model from R2, R3, R5
    task automatic model();
        int sel [NGRP];
        int best;
        int s;
        for (int g = 0; g < NGRP; g++) begin
            best = g * GRP;
            for (int j = 1; j < GRP; j++) begin
                if ((g % 2 == 0) ? (cur[g * GRP + j] > cur[best]) : (cur[g * GRP + j] < cur[best]))
                    best = g * GRP + j;
            end
            sel[g] = best;
        end
        exp_sad = 1 << 30;
        for (int dy = -RNG_V; dy <= RNG_V; dy++) begin
            for (int dx = -RNG_H; dx <= RNG_H; dx++) begin
                s = 0;
                for (int g = 0; g < NGRP; g++) begin
                    int d;
                    d = pix_at(cx + dx + sel[g] % BLK, cy + dy + sel[g] / BLK) - cur[sel[g]];
                    s += (d < 0) ? -d : d;
                end
                if (s < exp_sad) begin
                    exp_sad = s;
                    exp_x = cx + dx;
                    exp_y = cy + dy;
                end
            end
        end
    endtask

    task automatic wait_done(output bit got);
        got = 0;
        for (int i = 0; i < 4000 && !got; i++) begin
            if (done) got = 1;
            else @(negedge clk);
        end
    endtask

    task automatic judge(input string tag);
        chk("R7", {tag, " mv_x"}, mv_x, exp_x);
        chk("R7", {tag, " mv_y"}, mv_y, exp_y);
        chk("R3", {tag, " mv_sad"}, mv_sad, exp_sad);
        chk("R4", {tag, " read count"}, rd_cnt, NREAD);
        chk("R6", {tag, " reads outside window"}, win_bad, 0);
        chk("R8", {tag, " busy low in done cycle"}, busy, 0);
        @(negedge clk);
        chk("R7", {tag, " done one cycle"}, done, 0);
    endtask

    task automatic run_search(input string tag);
        bit got;
        rd_cnt = 0;
        win_bad = 0;
        ctr_x = CRD_W'(cx);
        ctr_y = CRD_W'(cy);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R8", {tag, " busy after start"}, busy, 1);
        wait_done(got);
        chk("R7", {tag, " done seen"}, got, 1);
        judge(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int seen;
        bit got;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9", "busy", busy, 0);
        chk("R9", "done", done, 0);
        chk("R9", "ref_rd", ref_rd, 0);
        chk("R9", "mv_x", mv_x, 0);
        chk("R9", "mv_sad", mv_sad, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: start without a loaded block is ignored
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            if (busy || done || ref_rd) seen++;
            @(negedge clk);
        end
        chk("R1", "activity after start with no block", seen, 0);

        // table walk: R2, R3, R4, R5, R6, R7
        for (int v = 0; v < 6; v++) begin
            cx = VECS[v].cx; cy = VECS[v].cy;
            px = VECS[v].px; py = VECS[v].py;
            plant = VECS[v].plant; rseed = VECS[v].rseed;
            load_block(VECS[v].cseed);
            model();
            run_search($sformatf("R2/R5 vec%0d", v));
        end

        // R5: copy planted at the last candidate wins in the final compare
        cx = 0; cy = 0; px = RNG_H; py = RNG_V; plant = 1; rseed = 21;
        load_block(6);
        model();
        run_search("R5 last candidate");
        chk("R5", "last candidate x", mv_x, RNG_H);
        chk("R5", "last candidate sad", mv_sad, 0);

        // R8: start and load attempts while busy are ignored
        cx = 2; cy = -1; px = -2; py = 1; plant = 1; rseed = 17;
        load_block(8);
        model();
        rd_cnt = 0;
        win_bad = 0;
        ctr_x = CRD_W'(cx);
        ctr_y = CRD_W'(cy);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 200; i++) begin
            cur_valid = 1'b1;
            cur_pix = 8'(i * 7);
            start = (i % 50 == 3);
            ctr_x = 7;
            ctr_y = 7;
            @(negedge clk);
        end
        cur_valid = 1'b0;
        start = 1'b0;
        wait_done(got);
        chk("R8", "done after busy-time pokes", got, 1);
        judge("R8 ignored during search");
        // block must be unchanged: rerun with the same centre
        run_search("R8 block retained");

        // R1: a fresh full load replaces the block
        cx = 0; cy = 1; px = 0; py = -1; plant = 1; rseed = 3;
        load_block(12);
        model();
        run_search("R1 reload");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule